// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block holds the programming state of a PLL-based clock generator behind a small synchronous byte bus. Six byte registers sit at consecutive addresses. They carry the PLL enable, the bus clock source select, the prescaler and VCO power-of-two selects, the automatic or manual loop bandwidth mode, a 12-bit feedback multiplier, an 8-bit VCO range code and a 4-bit reference divider. The PLL returns a lock indication and an acquisition status. Both can be read back, and in automatic mode a change of lock raises an event flag that can drive an interrupt.

The bank is not a plain register file. Bits in one register gate writes and readback in others. The divider setup freezes while the PLL runs. The PLL cannot be switched off while it clocks the bus. The bus cannot be moved onto the PLL while the PLL is off or the range code is zero. The interrupt machinery only works in automatic mode. A read has no wait state: `rd_data` follows `addr` in the same cycle. Any register side effect happens at the clock edge where `rd_en` is high.

Top module: `clkgen_regbank`

## Requirements
- R1: After reset the registers read as follows: offset 0 reads 0x20 (PLL enable set), offset 1 reads 0x00, offset 2 reads 0x00, offset 3 reads 0x40, offset 4 reads 0x40 and offset 5 reads 0x01. `irq` is low.
- R2: The registers sit at base 0x36 plus offsets 0..5, in this order: control, loop, multiplier high, multiplier low, range, reference divider. In the control byte, bit 7 is the interrupt enable, bit 6 the lock event flag, bit 5 the PLL enable and bit 4 the bus select. Bits 3:2 are the prescaler and bits 1:0 the VCO power. The same fields appear on the matching output ports.
- R3: While the loop auto bit (offset 1, bit 7) is 0, the interrupt enable stays 0 and ignores writes. The event flag and the lock readback (offset 1, bit 6) read 0.
- R4: While the auto bit is 1, offset 1 bit 5 reads the `acq_in` input and CPU writes to the stored acquisition bit (`acq_req`) have no effect. While the auto bit is 0, that bit is read/write.
- R5: While the PLL enable is 0, or the range register holds 0, the bus select stays 0 and ignores writes.
- R6: While the PLL enable is 1, writes to the multiplier, range and reference divider registers have no effect. The multiplier's upper 4 bits are bits 3:0 of offset 2 and its lower 8 bits are offset 3. The divider is bits 3:0 of offset 5.
- R7: While the bus select is 1, the PLL enable stays 1 and a write of 0 to it has no effect.
- R8: With the auto bit set, any change of `lock_in` sets the event flag on the next edge. A read of the control byte clears the flag, and a new lock change in the same cycle wins over the clear. `irq` is high exactly while both the flag and the interrupt enable are set.
- R9: Addresses outside the six-byte window read 0 and writes to them change nothing. Unimplemented bits read 0, including bits 4:0 of offset 1 and the upper nibbles of offsets 2 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects on read) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| lock_in | input | 1 | Lock status from the PLL |
| acq_in | input | 1 | Acquisition status from the PLL |
| irq | output | 1 | Lock event interrupt |
| pll_en | output | 1 | PLL enable |
| bus_sel | output | 1 | Bus clock taken from the PLL |
| prescale | output | 2 | Prescaler select |
| vco_pow | output | 2 | VCO power-of-two select |
| auto_bw | output | 1 | Automatic bandwidth mode |
| acq_req | output | 1 | Stored manual acquisition bit |
| mult | output | MUL_W | Feedback multiplier |
| vco_range | output | RANGE_W | VCO range code |
| ref_div | output | RDIV_W | Reference divider |

## Verification
The bench builds the bank with its default parameters: base 0x36, a 12-bit multiplier, an 8-bit range and a 4-bit divider, with reset values 0x040, 0x40 and 0x1. Because the range resets to a non-zero value, the PLL-drives-bus state can be reached right after the divider setup is unlocked. That makes the interlock between the bus select and the PLL enable testable from both sides. The 12-bit multiplier splits across two bytes, so the bench can see the masking of the high nibble and of the divider byte. Lock toggles are timed against control reads, including the case where both fall in the same cycle.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  localparam int NUM_REGS = 6;

  // Register offsets; the order is part of the programming model.
  localparam int OFS_CTRL  = 0;
  localparam int OFS_LOOP  = 1;
  localparam int OFS_MULH  = 2;
  localparam int OFS_MULL  = 3;
  localparam int OFS_RANGE = 4;
  localparam int OFS_RDIV  = 5;

  // Bit positions inside the control byte.
  localparam int B_INT_EN  = 7;
  localparam int B_EVT     = 6;
  localparam int B_PLL_EN  = 5;
  localparam int B_BUS_SEL = 4;

  // Bit positions inside the loop byte.
  localparam int B_AUTO = 7;
  localparam int B_LOCK = 6;
  localparam int B_ACQ  = 5;

  // The bus may move onto the PLL only when it runs with a usable range.
  function automatic logic bus_sel_allowed(logic pll_on, logic range_is_zero);
    return pll_on & ~range_is_zero;
  endfunction

  // Readback of the loop byte; status bits depend on the mode.
  function automatic logic [7:0] loop_readback(logic auto_on, logic lock, logic acq_live,
                                               logic acq_stored);
    logic [7:0] v;
    v         = 8'h00;
    v[B_AUTO] = auto_on;
    v[B_LOCK] = auto_on & lock;
    v[B_ACQ]  = auto_on ? acq_live : acq_stored;
    return v;
  endfunction

endpackage

// File: rtl/cgr_decode.sv
module cgr_decode #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h36
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic [cgr_pkg::NUM_REGS-1:0] sel
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] ofs;
  assign ofs = addr - BASE;

  for (genvar i = 0; i < cgr_pkg::NUM_REGS; i++) begin : g_sel
    assign sel[i] = (ofs == ADDR_W'(i));
  end

  always_comb begin
    a_sel_onehot_r9 : assert ($onehot0(sel));
  end
endmodule

// File: rtl/cgr_cfg.sv
module cgr_cfg #(
  parameter int MUL_W     = 12,
  parameter int RANGE_W   = 8,
  parameter int RDIV_W    = 4,
  parameter int MUL_RST   = 'h040,
  parameter int RANGE_RST = 'h40,
  parameter int RDIV_RST  = 'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mulh,
  input  logic               wr_mull,
  input  logic               wr_range,
  input  logic               wr_rdiv,
  input  logic [7:0]         wdata,
  input  logic               pll_on,
  output logic [MUL_W-1:0]   mult,
  output logic [RANGE_W-1:0] vco_range,
  output logic [RDIV_W-1:0]  ref_div,
  output logic               range_zero,
  output logic [7:0]         mulh_rd,
  output logic [7:0]         mull_rd,
  output logic [7:0]         range_rd,
  output logic [7:0]         rdiv_rd
);
  logic [MUL_W-1:0]   mult_q;
  logic [RANGE_W-1:0] range_q;
  logic [RDIV_W-1:0]  rdiv_q;
  logic [15:0]        mul_ext;
  logic [15:0]        mul_new;
  logic               unlocked;
  logic               unused_bits;

  assign unlocked = ~pll_on;
  assign mul_ext  = 16'(mult_q);

  always_comb begin
    mul_new = mul_ext;
    if (wr_mulh) mul_new[15:8] = wdata;
    if (wr_mull) mul_new[7:0]  = wdata;
  end

  assign unused_bits = ^{mul_new[15:MUL_W], wdata[7:RDIV_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q  <= MUL_W'(MUL_RST);
      range_q <= RANGE_W'(RANGE_RST);
      rdiv_q  <= RDIV_W'(RDIV_RST);
    end else if (unlocked) begin
      if (wr_mulh || wr_mull) mult_q <= mul_new[MUL_W-1:0];
      if (wr_range)           range_q <= wdata[RANGE_W-1:0];
      if (wr_rdiv)            rdiv_q  <= wdata[RDIV_W-1:0];
    end
  end

  assign mult       = mult_q;
  assign vco_range  = range_q;
  assign ref_div    = rdiv_q;
  assign range_zero = (range_q == '0);
  assign mulh_rd    = mul_ext[15:8];
  assign mull_rd    = mul_ext[7:0];
  assign range_rd   = 8'(range_q);
  assign rdiv_rd    = 8'(rdiv_q);

  p_cfg_frozen_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |=> ($stable(mult_q) && $stable(range_q) && $stable(rdiv_q)));
endmodule

// File: rtl/cgr_ctrl.sv
module cgr_ctrl
  import cgr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_loop,
  input  logic       rd_ctrl,
  input  logic [7:0] wdata,
  input  logic       lock_in,
  input  logic       acq_in,
  input  logic       range_zero,
  output logic [7:0] ctrl_rd,
  output logic [7:0] loop_rd,
  output logic       pll_en,
  output logic       bus_sel,
  output logic [1:0] prescale,
  output logic [1:0] vco_pow,
  output logic       auto_bw,
  output logic       acq_req,
  output logic       irq
);
  logic       int_en_q, evt_q, pll_en_q, bus_sel_q, auto_q, acq_q, lock_d;
  logic [1:0] prescale_q, vco_pow_q;
  logic       int_en_d, evt_d, pll_en_d, bus_sel_d, auto_d, acq_d;
  logic [1:0] prescale_d, vco_pow_d;
  logic       lock_evt;

  // Named internal event: a lock transition seen in automatic mode.
  assign lock_evt = auto_q & (lock_in ^ lock_d);

  always_comb begin
    int_en_d   = auto_q & (wr_ctrl ? wdata[B_INT_EN] : int_en_q);
    evt_d      = auto_q & (lock_evt | (evt_q & ~rd_ctrl));
    pll_en_d   = bus_sel_q | (wr_ctrl ? wdata[B_PLL_EN] : pll_en_q);
    bus_sel_d  = bus_sel_allowed(pll_en_q, range_zero) &
                 (wr_ctrl ? wdata[B_BUS_SEL] : bus_sel_q);
    prescale_d = wr_ctrl ? wdata[3:2] : prescale_q;
    vco_pow_d  = wr_ctrl ? wdata[1:0] : vco_pow_q;
    auto_d     = wr_loop ? wdata[B_AUTO] : auto_q;
    acq_d      = (wr_loop && !auto_q) ? wdata[B_ACQ] : acq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en_q   <= 1'b0;
      evt_q      <= 1'b0;
      pll_en_q   <= 1'b1;
      bus_sel_q  <= 1'b0;
      prescale_q <= 2'b00;
      vco_pow_q  <= 2'b00;
      auto_q     <= 1'b0;
      acq_q      <= 1'b0;
      lock_d     <= 1'b0;
    end else begin
      int_en_q   <= int_en_d;
      evt_q      <= evt_d;
      pll_en_q   <= pll_en_d;
      bus_sel_q  <= bus_sel_d;
      prescale_q <= prescale_d;
      vco_pow_q  <= vco_pow_d;
      auto_q     <= auto_d;
      acq_q      <= acq_d;
      lock_d     <= lock_in;
    end
  end

  assign ctrl_rd  = {int_en_q, evt_q & auto_q, pll_en_q, bus_sel_q, prescale_q, vco_pow_q};
  assign loop_rd  = loop_readback(auto_q, lock_in, acq_in, acq_q);
  assign pll_en   = pll_en_q;
  assign bus_sel  = bus_sel_q;
  assign prescale = prescale_q;
  assign vco_pow  = vco_pow_q;
  assign auto_bw  = auto_q;
  assign acq_req  = acq_q;
  assign irq      = evt_q & int_en_q;

  p_int_en_gate_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |=> !int_en_q && !evt_q);
  p_acq_frozen_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> $stable(acq_q));
  p_bus_guard_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en_q || range_zero) |=> !bus_sel_q);
  p_pll_held_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_q |=> pll_en_q);
  p_evt_set_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> evt_q);
  p_evt_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !lock_evt) |=> !evt_q);
endmodule

// File: rtl/clkgen_regbank.sv
module clkgen_regbank #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h36,
  parameter int MUL_W     = 12,
  parameter int RANGE_W   = 8,
  parameter int RDIV_W    = 4,
  parameter int MUL_RST   = 'h040,
  parameter int RANGE_RST = 'h40,
  parameter int RDIV_RST  = 'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic               lock_in,
  input  logic               acq_in,
  output logic               irq,
  output logic               pll_en,
  output logic               bus_sel,
  output logic [1:0]         prescale,
  output logic [1:0]         vco_pow,
  output logic               auto_bw,
  output logic               acq_req,
  output logic [MUL_W-1:0]   mult,
  output logic [RANGE_W-1:0] vco_range,
  output logic [RDIV_W-1:0]  ref_div
);
  import cgr_pkg::*;

  logic [NUM_REGS-1:0] sel, wsel;
  logic [7:0]          rd_vec [NUM_REGS];
  logic                range_zero;

  cgr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  assign wsel = sel & {NUM_REGS{wr_en}};

  cgr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wsel[OFS_CTRL]),
    .wr_loop    (wsel[OFS_LOOP]),
    .rd_ctrl    (rd_en & sel[OFS_CTRL]),
    .wdata      (wr_data),
    .lock_in    (lock_in),
    .acq_in     (acq_in),
    .range_zero (range_zero),
    .ctrl_rd    (rd_vec[OFS_CTRL]),
    .loop_rd    (rd_vec[OFS_LOOP]),
    .pll_en     (pll_en),
    .bus_sel    (bus_sel),
    .prescale   (prescale),
    .vco_pow    (vco_pow),
    .auto_bw    (auto_bw),
    .acq_req    (acq_req),
    .irq        (irq)
  );

  cgr_cfg #(
    .MUL_W(MUL_W), .RANGE_W(RANGE_W), .RDIV_W(RDIV_W),
    .MUL_RST(MUL_RST), .RANGE_RST(RANGE_RST), .RDIV_RST(RDIV_RST)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mulh    (wsel[OFS_MULH]),
    .wr_mull    (wsel[OFS_MULL]),
    .wr_range   (wsel[OFS_RANGE]),
    .wr_rdiv    (wsel[OFS_RDIV]),
    .wdata      (wr_data),
    .pll_on     (pll_en),
    .mult       (mult),
    .vco_range  (vco_range),
    .ref_div    (ref_div),
    .range_zero (range_zero),
    .mulh_rd    (rd_vec[OFS_MULH]),
    .mull_rd    (rd_vec[OFS_MULL]),
    .range_rd   (rd_vec[OFS_RANGE]),
    .rdiv_rd    (rd_vec[OFS_RDIV])
  );

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rd_data = rd_data | rd_vec[i];
    end
  end
endmodule

// File: tb/test_clkgen_regbank.sv
module test_clkgen_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        lock_in = 1'b0;
  logic        acq_in = 1'b0;
  logic        irq, pll_en, bus_sel, auto_bw, acq_req;
  logic [1:0]  prescale, vco_pow;
  logic [11:0] mult;
  logic [7:0]  vco_range;
  logic [3:0]  ref_div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h36, A_LOOP = 8'h37, A_MULH = 8'h38,
                         A_MULL = 8'h39, A_RANGE = 8'h3A, A_RDIV = 8'h3B;

  always #2.5 clk = ~clk;

  clkgen_regbank i_clkgen_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .lock_in(lock_in), .acq_in(acq_in),
    .irq(irq), .pll_en(pll_en), .bus_sel(bus_sel), .prescale(prescale),
    .vco_pow(vco_pow), .auto_bw(auto_bw), .acq_req(acq_req), .mult(mult),
    .vco_range(vco_range), .ref_div(ref_div)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    check(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    read_check("R1 ctrl", A_CTRL, 8'h20);
    read_check("R1 loop", A_LOOP, 8'h00);
    read_check("R1 mulh", A_MULH, 8'h00);
    read_check("R1 mull", A_MULL, 8'h40);
    read_check("R1 range", A_RANGE, 8'h40);
    read_check("R1 rdiv", A_RDIV, 8'h01);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_cfg_lock;
    bus_write(A_MULL, 8'hAA);
    read_check("R6 mull frozen", A_MULL, 8'h40);
    bus_write(A_CTRL, 8'h00);
    bus_write(A_MULH, 8'hFF);
    bus_write(A_MULL, 8'h34);
    bus_write(A_RANGE, 8'h00);
    bus_write(A_RDIV, 8'hF7);
    read_check("R6 mulh", A_MULH, 8'h0F);
    read_check("R6 mull", A_MULL, 8'h34);
    read_check("R6 range", A_RANGE, 8'h00);
    read_check("R6 rdiv", A_RDIV, 8'h07);
    check("R6 mult port", mult, 12'hF34);
  endtask

  task automatic t_bus_guard;
    bus_write(A_CTRL, 8'h10);
    read_check("R5 pll off", A_CTRL, 8'h00);
    bus_write(A_CTRL, 8'h30);
    read_check("R5 same-cycle enable", A_CTRL, 8'h20);
    bus_write(A_CTRL, 8'h30);
    read_check("R5 range zero", A_CTRL, 8'h20);
    check("R5 bus port", bus_sel, 0);
  endtask

  task automatic t_pll_hold;
    bus_write(A_CTRL, 8'h00);
    bus_write(A_RANGE, 8'h55);
    bus_write(A_CTRL, 8'h20);
    bus_write(A_CTRL, 8'h3B);
    read_check("R2 ctrl layout", A_CTRL, 8'h3B);
    check("R2 prescale", prescale, 2);
    check("R2 vco_pow", vco_pow, 3);
    check("R2 bus_sel", bus_sel, 1);
    bus_write(A_RANGE, 8'h11);
    read_check("R6 range frozen", A_RANGE, 8'h55);
    bus_write(A_CTRL, 8'h00);
    read_check("R7 pll held", A_CTRL, 8'h20);
    bus_write(A_CTRL, 8'h00);
    read_check("R7 pll released", A_CTRL, 8'h00);
    check("R7 pll port", pll_en, 0);
  endtask

  task automatic t_manual_mode;
    bus_write(A_CTRL, 8'hA0);
    read_check("R3 int_en held", A_CTRL, 8'h20);
    @(negedge clk) lock_in = 1'b1;
    @(negedge clk);
    read_check("R3 lock reads 0", A_LOOP, 8'h00);
    read_check("R3 no flag", A_CTRL, 8'h20);
    check("R3 irq", irq, 0);
    bus_write(A_LOOP, 8'h20);
    read_check("R4 manual acq", A_LOOP, 8'h20);
    check("R4 acq port", acq_req, 1);
    bus_write(A_LOOP, 8'h00);
    read_check("R4 manual clear", A_LOOP, 8'h00);
  endtask

  task automatic t_auto_mode;
    bus_write(A_LOOP, 8'hA0);
    @(negedge clk) acq_in = 1'b0;
    read_check("R4 live acq 0", A_LOOP, 8'hC0);
    bus_write(A_LOOP, 8'h80);
    check("R4 write ignored", acq_req, 1);
    @(negedge clk) acq_in = 1'b1;
    read_check("R4 live acq 1", A_LOOP, 8'hE0);
  endtask

  task automatic t_lock_event;
    bus_write(A_CTRL, 8'hA0);
    read_check("R8 enable no flag", A_CTRL, 8'hA0);
    check("R8 irq idle", irq, 0);
    @(negedge clk) lock_in = 1'b0;
    @(negedge clk);
    check("R8 irq on change", irq, 1);
    read_check("R8 flag read", A_CTRL, 8'hE0);
    check("R8 cleared by read", irq, 0);
    read_check("R8 flag gone", A_CTRL, 8'hA0);
    @(negedge clk) lock_in = 1'b1;
    @(negedge clk);
    check("R8 irq second", irq, 1);
    @(negedge clk);
    addr = A_CTRL; rd_en = 1'b1; lock_in = 1'b0;
    #1 check("R8 read data", rd_data, 8'hE0);
    @(negedge clk) rd_en = 1'b0;
    check("R8 set wins", irq, 1);
    read_check("R8 clear", A_CTRL, 8'hE0);
    check("R8 irq low", irq, 0);
    bus_write(A_LOOP, 8'h00);
    read_check("R3 leave auto", A_CTRL, 8'h20);
    check("R3 irq off", irq, 0);
  endtask

  task automatic t_outside;
    bus_write(8'h3C, 8'hFF);
    bus_write(8'h35, 8'hFF);
    read_check("R9 above window", 8'h3C, 8'h00);
    read_check("R9 below window", 8'h35, 8'h00);
    read_check("R9 ctrl untouched", A_CTRL, 8'h20);
    read_check("R9 rdiv untouched", A_RDIV, 8'h07);
    bus_write(A_LOOP, 8'h1F);
    read_check("R9 loop spare bits", A_LOOP, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_lock();
    t_bus_guard();
    t_pll_hold();
    t_manual_mode();
    t_auto_mode();
    t_lock_event();
    t_outside();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule